// File: doc/BRIEF.md
# Radix-2 DIF butterfly address sequencer

This block drives an in-place, memory-based radix-2 decimation-in-frequency FFT of fixed length N = 2^n. A single start pulse sets it running. It then walks through all n stages. In each stage it issues N/2 butterflies, one per accepted handshake. For every butterfly it presents two data memory addresses, which the datapath uses to read the two operands and later to write the two results back to the same locations. With the addresses it presents the twiddle exponent for that butterfly.

The butterflies within a stage are not visited top to bottom. Those that share a twiddle factor are issued back to back. To get this order, a stage digit (0 for the upper operand, 1 for the lower) is placed above the (n-1)-bit butterfly count. The n-bit word is then rotated right by the stage number. The twiddle exponent depends only on the butterfly count and the stage number. A whole transform takes (N/2)·n handshakes. With two reads and two writes per butterfly, that is 2·N·n memory accesses.

A consumer takes an output by raising `ready` while `valid` is high. The butterfly arithmetic, the data memory and the coefficient table all lie outside this block.

Top module: `fft_r2_agen`

## Requirements
- R1: After reset, `valid`, `stage_last` and `done` are low, and they stay low until a start is accepted.
- R2: A `start` seen high at a clock edge while the block is idle makes `valid` high from the next cycle on, with stage 0 and butterfly 0 presented, which gives the pair `addr_s`=0, `addr_t`=N/2. Without a start the block stays idle even when `ready` is high.
- R3: For stage k and butterfly count i, `addr_s` is the n-bit word {0,i} rotated right by k bits, and `addr_t` is {1,i} rotated right by k bits. For N=16 this gives: stage 1 starts <0,4>,<8,12>,<1,5>; stage 2 starts <0,2>,<4,6>,<8,10>,<12,14>,<1,3>; stage 3 runs <0,1>,<2,3>,…,<14,15>.
- R4: `tw_exp` equals i with its k lowest bits cleared, that is (i>>k)<<k, taken modulo N/2. For N=16, stage 1, i=1 gives 0.
- R5: The outputs move to the next butterfly only at an edge where `valid` and `ready` are both high. While `ready` is low, the addresses, the exponent and `valid` all hold.
- R6: Within a stage, the butterfly count runs 0 to N/2−1. After the last one, the stage count goes up by one and the butterfly count returns to 0. A transform therefore takes exactly (N/2)·n accepted handshakes.
- R7: `stage_last` is high exactly while `valid` is high in stage n−1.
- R8: `done` is high for exactly one cycle, the cycle right after the final butterfly of stage n−1 is accepted. In that cycle `valid` is already low.
- R9: `start` has no effect while a transform is running.
- R10: The two addresses of every butterfly differ in exactly one bit, and that bit is 0 in `addr_s`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a transform when idle |
| ready | input | 1 | Consumer accepts the presented butterfly |
| addr_s | output | log2 N | Upper operand address |
| addr_t | output | log2 N | Lower operand address |
| tw_exp | output | log2 N − 1 | Twiddle exponent |
| valid | output | 1 | A butterfly is presented |
| stage_last | output | 1 | Presented butterfly belongs to the final stage |
| done | output | 1 | One-cycle pulse after the transform completes |

## Verification
Every output comes from registered counters through combinational logic only. `valid` and the first pair therefore appear one cycle after the edge that samples `start`. Each accepted handshake moves the addresses and the exponent at that same edge, and `done` rises on the edge that takes the final handshake. The bench drives inputs and compares outputs at the falling edge. After each rising edge it recomputes the expected stage and butterfly from the handshakes it has made itself, so every comparison lands one register after its cause. Stalled cycles are compared against the same expected butterfly as before, and starts injected mid-run must leave that expectation unchanged.

// File: rtl/agen_pkg.sv
package agen_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  // twiddle exponent: butterfly count with its k low bits cleared
  function automatic int unsigned tw_of(input int unsigned cnt, input int unsigned k);
    return (cnt >> k) << k;
  endfunction

endpackage

// File: rtl/agen_seq.sv
module agen_seq
  import agen_pkg::*;
#(
  parameter int AW = 4,
  localparam int BW = AW - 1,
  localparam int SW = $clog2(AW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          ready,
  output logic [SW-1:0] stage,
  output logic [BW-1:0] bf,
  output logic          valid,
  output logic          stage_last,
  output logic          done,
  output logic          fire,
  output logic          stage_step,
  output logic          xfer_end
);

  localparam logic [SW-1:0] LAST_STAGE = SW'(AW - 1);
  localparam logic [BW-1:0] LAST_BF    = {BW{1'b1}};

  seq_state_e    state_q;
  logic [SW-1:0] stage_q;
  logic [BW-1:0] bf_q;
  logic          done_q;
  logic          bf_wrap;
  logic          at_last;

  assign valid      = (state_q == SEQ_RUN);
  assign at_last    = (stage_q == LAST_STAGE);
  assign bf_wrap    = (bf_q == LAST_BF);
  assign fire       = valid & ready;
  assign stage_step = fire & bf_wrap & ~at_last;
  assign xfer_end   = fire & bf_wrap & at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      stage_q <= '0;
      bf_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= xfer_end;
      case (state_q)
        SEQ_IDLE: begin
          if (start) begin
            state_q <= SEQ_RUN;
            stage_q <= '0;
            bf_q    <= '0;
          end
        end
        default: begin
          if (fire) begin
            if (bf_wrap) begin
              bf_q <= '0;
              if (at_last) begin
                state_q <= SEQ_IDLE;
                stage_q <= '0;
              end else begin
                stage_q <= stage_q + 1'b1;
              end
            end else begin
              bf_q <= bf_q + 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign stage      = stage_q;
  assign bf         = bf_q;
  assign stage_last = valid & at_last;
  assign done       = done_q;

endmodule

// File: rtl/agen_rot.sv
module agen_rot #(
  parameter int AW = 4,
  localparam int SW = $clog2(AW)
) (
  input  logic [AW-1:0] word,
  input  logic [SW-1:0] amt,
  output logic [AW-1:0] rotated
);

  function automatic logic [AW-1:0] rotr(input logic [AW-1:0] w, input logic [SW-1:0] k);
    logic [2*AW-1:0] dbl;
    dbl = {w, w} >> k;
    return dbl[AW-1:0];
  endfunction

  assign rotated = rotr(word, amt);

endmodule

// File: rtl/agen_twiddle.sv
module agen_twiddle
  import agen_pkg::*;
#(
  parameter int AW = 4,
  localparam int BW = AW - 1,
  localparam int SW = $clog2(AW)
) (
  input  logic [SW-1:0] stage,
  input  logic [BW-1:0] bf,
  output logic [BW-1:0] tw
);

  int unsigned full;

  assign full = tw_of(32'(bf), 32'(stage));
  assign tw   = full[BW-1:0];

endmodule

// File: rtl/fft_r2_agen.sv
module fft_r2_agen #(
  parameter int N = 16,
  localparam int AW = $clog2(N),
  localparam int BW = AW - 1,
  localparam int SW = $clog2(AW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          ready,
  output logic [AW-1:0] addr_s,
  output logic [AW-1:0] addr_t,
  output logic [BW-1:0] tw_exp,
  output logic          valid,
  output logic          stage_last,
  output logic          done
);

  logic [SW-1:0] stage;
  logic [BW-1:0] bf;
  logic          fire;
  logic          stage_step;
  logic          xfer_end;
  logic [AW-1:0] addr_pair [2];

  agen_seq #(.AW(AW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .ready      (ready),
    .stage      (stage),
    .bf         (bf),
    .valid      (valid),
    .stage_last (stage_last),
    .done       (done),
    .fire       (fire),
    .stage_step (stage_step),
    .xfer_end   (xfer_end)
  );

  for (genvar g = 0; g < 2; g++) begin : g_leg
    logic [AW-1:0] word;
    assign word = {(g == 1) ? 1'b1 : 1'b0, bf};
    agen_rot #(.AW(AW)) u_rot (
      .word    (word),
      .amt     (stage),
      .rotated (addr_pair[g])
    );
  end

  agen_twiddle #(.AW(AW)) u_tw (
    .stage (stage),
    .bf    (bf),
    .tw    (tw_exp)
  );

  assign addr_s = addr_pair[0];
  assign addr_t = addr_pair[1];

endmodule

// File: rtl/agen_check.sv
module agen_check #(
  parameter int AW = 4,
  localparam int BW = AW - 1,
  localparam int SW = $clog2(AW)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          ready,
  input logic [AW-1:0] addr_s,
  input logic [AW-1:0] addr_t,
  input logic [BW-1:0] tw_exp,
  input logic          valid,
  input logic          stage_last,
  input logic          done,
  input logic [SW-1:0] stage,
  input logic          stage_step,
  input logic          xfer_end
);

  logic [BW-1:0] low_mask;
  assign low_mask = BW'((32'd1 << stage) - 32'd1);

  a_r10_one_bit_apart: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ($countones(addr_s ^ addr_t) == 1) && ((addr_s & addr_t) == addr_s));

  a_r5_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> valid && $stable(addr_s) && $stable(addr_t) && $stable(tw_exp));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |=> done && !valid);

  a_r7_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    stage_last |-> valid);

  a_r4_tw_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ((tw_exp & low_mask) == '0));

  a_r6_stage_advance: assert property (@(posedge clk) disable iff (!rst_n)
    stage_step |=> valid && (stage == $past(stage) + 1'b1));

  a_r9_start_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && start && !xfer_end) |=> valid);

endmodule

bind fft_r2_agen agen_check #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .ready      (ready),
  .addr_s     (addr_s),
  .addr_t     (addr_t),
  .tw_exp     (tw_exp),
  .valid      (valid),
  .stage_last (stage_last),
  .done       (done),
  .stage      (stage),
  .stage_step (stage_step),
  .xfer_end   (xfer_end)
);

// File: tb/fft_r2_agen_bench.sv
module fft_r2_agen_bench;

  localparam int N  = 16;
  localparam int AW = $clog2(N);
  localparam int BW = AW - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          ready = 1'b0;
  logic [AW-1:0] addr_s, addr_t;
  logic [BW-1:0] tw_exp;
  logic          valid, stage_last, done;

  int n_run  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit ended  = 1'b0;

  always #10 clk = ~clk;

  fft_r2_agen #(.N(N)) u_fft_r2_agen (
    .clk(clk), .rst_n(rst_n), .start(start), .ready(ready),
    .addr_s(addr_s), .addr_t(addr_t), .tw_exp(tw_exp),
    .valid(valid), .stage_last(stage_last), .done(done)
  );

  // upper address: low k bits of i move to the top, the rest sit below the stage digit
  function automatic int exp_s(input int k, input int i);
    return ((i % (1 << k)) << (AW - k)) + (i >> k);
  endfunction

  function automatic int exp_t(input int k, input int i);
    return exp_s(k, i) + (1 << (AW - 1 - k));
  endfunction

  function automatic int exp_tw(input int k, input int i);
    return (i / (1 << k)) * (1 << k);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      finish_up();
    end
  end

  task automatic do_run(input int pct, input bit poke);
    int  accepted = 0;
    bit  stalled  = 1'b0;
    bit  poked    = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(valid == 1'b1, "R2 valid after start", int'(valid), 1);
    chk(addr_s == 0 && addr_t == N / 2, "R2 first pair t", int'(addr_t), N / 2);
    for (int k = 0; k < AW; k++) begin
      for (int i = 0; i < N / 2; i++) begin
        bit acc = 1'b0;
        while (!acc) begin
          string tg;
          tg = stalled ? "R5 hold" : (poked ? "R9 start ignored" : "R3 addr_s");
          chk(valid == 1'b1, "R6 valid in run", int'(valid), 1);
          chk(int'(addr_s) == exp_s(k, i), tg, int'(addr_s), exp_s(k, i));
          chk(int'(addr_t) == exp_t(k, i), "R3 addr_t", int'(addr_t), exp_t(k, i));
          chk(int'(tw_exp) == exp_tw(k, i), "R4 tw_exp", int'(tw_exp), exp_tw(k, i));
          chk(stage_last == (k == AW - 1), "R7 stage_last", int'(stage_last), int'(k == AW - 1));
          chk(done == 1'b0, "R8 done low in run", int'(done), 0);
          if (k == 1 && i == 1)
            chk(addr_s == 8 && addr_t == 12, "R3 N16 stage1 bf1 s", int'(addr_s), 8);
          if (k == 2 && i == 4)
            chk(addr_s == 1 && addr_t == 3, "R3 N16 stage2 bf4 s", int'(addr_s), 1);
          acc     = (($urandom % 100) < pct);
          ready   = acc;
          poked   = poke && (($urandom % 3) == 0);
          start   = poked;
          stalled = !acc;
          if (acc) accepted++;
          @(negedge clk);
        end
      end
    end
    start = 1'b0;
    ready = 1'b0;
    chk(accepted == (N / 2) * AW, "R6 handshake count", accepted, (N / 2) * AW);
    chk(done == 1'b1, "R8 done pulse", int'(done), 1);
    chk(valid == 1'b0, "R8 valid low at done", int'(valid), 0);
    @(negedge clk);
    chk(done == 1'b0, "R8 done one cycle", int'(done), 0);
    chk(valid == 1'b0, "R8 idle after done", int'(valid), 0);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk(valid == 1'b0, "R1 valid reset", int'(valid), 0);
    chk(done == 1'b0, "R1 done reset", int'(done), 0);
    chk(stage_last == 1'b0, "R1 stage_last reset", int'(stage_last), 0);
    rst_n = 1'b1;
    ready = 1'b1;
    repeat (4) @(negedge clk);
    chk(valid == 1'b0, "R2 idle without start", int'(valid), 0);
    chk(done == 1'b0, "R1 done idle", int'(done), 0);
    ready = 1'b0;
    do_run(100, 1'b0);
    do_run(60, 1'b1);
    do_run(30, 1'b1);
    ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(valid == 1'b0, "R2 stays idle", int'(valid), 0);
    finish_up();
  end

endmodule